// File: doc/BRIEF.md
# SECDED-Protected Eight-Entry Register File with Error Tallies

This block stores eight 32-bit words. Each word is held as a 39-bit codeword: the 32 data bits, six Hamming check bits and one overall parity bit. A write strobe encodes the input word and stores it in the entry chosen by a 3-bit index. A read strobe decodes the chosen entry and, one clock later, presents the data together with a 2-bit status. A single flipped bit is corrected. The corrected codeword is written back into the entry, which scrubs the fault. A double flip is reported as uncorrectable and the data is returned raw. Two saturating counters keep a tally of the corrected reads and the uncorrectable reads.

A small bus slave gives access to the corrected-error tally. It has a valid input, a byte-strobe input, write data, an acknowledge output and read data. An accepted bus access loads the tally into the read data. If any strobe bit is set, the access also clears the tally. For test, an XOR mask input can flip any chosen stored bits of the selected entry. This lets a bench plant single and double faults.

The storage path runs one operation per cycle. The operation is picked by priority and named by an enumerated kind: OP_IDLE, OP_WRITE, OP_READ or OP_INJECT. The bus slave is a two-state machine. BUS_IDLE goes to BUS_ACK when valid is seen. BUS_ACK always returns to BUS_IDLE on the next edge, and the acknowledge is high only in BUS_ACK.

Top module: `ecc_regfile`

## Requirements
- R1: After a synchronous active-high reset, every entry holds an all-zero codeword, so a read returns 0 with status 00. Both tallies are 0, and rd_data, rd_status, bus_ack and bus_rdata are 0.
- R2: A write (wr_en) stores wr_data in entry reg_sel. A read (rd_en) updates rd_data and rd_status at the next clock edge. In cycles without an accepted read, both outputs hold their value.
- R3: Codeword layout. Bit 0 is the overall even parity of bits 38:1. The check bits sit at positions 1, 2, 4, 8, 16 and 32. Data bit j sits at the (j+1)-th position in 3..38 that is not a power of two, taken in ascending order. The syndrome is the XOR of the positions of all set bits in 38:1.
- R4: A read of an entry with one flipped bit reports status 01 and returns the original data. This holds whichever bit flipped, including a check bit or the parity bit.
- R5: A read that corrects a bit writes the corrected codeword back, so a second read of that entry reports status 00.
- R6: A read of an entry with two flipped bits reports status 10. It returns the stored data bits uncorrected and leaves the entry unchanged.
- R7: rd_status never takes the value 11.
- R8: Each read with status 01 adds one to the corrected tally. Each read with status 10 adds one to the uncorrectable tally, which drives dbl_count zero-extended.
- R9: Both tallies stop at 2^CNT_W-1 and do not wrap.
- R10: Priority is write, then read, then inject. When wr_en and rd_en are both high, the read is not performed and the outputs hold. inj_en (which XORs inj_mask into entry reg_sel) has no effect in a cycle with either strobe high.
- R11: bus_ack is high for exactly one cycle, in the cycle after an accepted valid. While valid is held high, accesses are accepted on alternate cycles.
- R12: An accepted bus access loads bus_rdata with the corrected tally as it was before that edge. The access clears the tally if any bus_be bit is 1, and this clear wins over a same-edge increment. With bus_be at 0000 the access is still acknowledged, and the tally is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| reg_sel | input | 3 | Entry index for write, read and inject |
| wr_data | input | 32 | Data to store |
| rd_data | output | 32 | Data from the last read |
| rd_status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| inj_en | input | 1 | Test fault-injection enable |
| inj_mask | input | 39 | Bits to flip in the selected codeword |
| bus_valid | input | 1 | Bus cycle and strobe combined |
| bus_be | input | 4 | Bus byte strobes; any set bit clears the tally |
| bus_wdata | input | 32 | Bus write data (value not used) |
| bus_ack | output | 1 | Bus acknowledge |
| bus_rdata | output | 32 | Corrected-error tally |
| dbl_count | output | 32 | Uncorrectable-error tally |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it. This covers read data and status, the tally changes, scrubbing and the bus acknowledge with its read data. An injected fault is seen by the first read issued after the inject edge. The bench changes inputs on the falling edge and has its behavioural model predict the state after the next rising edge. It then compares all outputs at the following falling edge, every cycle, so no check samples at an edge. Scrubbing and clearing are observed through later reads and bus accesses, and never through internal state.

// File: rtl/ecc_rf_pkg.sv
package ecc_rf_pkg;

    localparam int DATA_W = 32;
    localparam int PAR_W  = 6;
    localparam int CW_W   = DATA_W + PAR_W + 1;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'b00,
        ST_FIXED = 2'b01,
        ST_FATAL = 2'b10
    } rd_status_e;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_WRITE,
        OP_READ,
        OP_INJECT
    } op_kind_e;

    typedef enum logic {
        BUS_IDLE,
        BUS_ACK
    } bus_state_e;

    function automatic logic is_pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    function automatic logic [CW_W-1:0] secded_encode(input logic [DATA_W-1:0] d);
        logic [CW_W-1:0]  cw;
        logic [PAR_W-1:0] syn;
        int k;
        cw  = '0;
        syn = '0;
        k   = 0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_pow2(p)) begin
                cw[p] = d[k];
                if (d[k]) syn ^= PAR_W'(p);
                k++;
            end
        end
        for (int i = 0; i < PAR_W; i++) cw[1 << i] = syn[i];
        cw[0] = ^cw[CW_W-1:1];
        return cw;
    endfunction

    function automatic logic [DATA_W-1:0] secded_extract(input logic [CW_W-1:0] cw);
        logic [DATA_W-1:0] d;
        int k;
        d = '0;
        k = 0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_pow2(p)) begin
                d[k] = cw[p];
                k++;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/ecc_rf_decoder.sv
module ecc_rf_decoder
    import ecc_rf_pkg::*;
(
    input  logic [CW_W-1:0]   cw_i,
    output logic [DATA_W-1:0] data_o,
    output logic [CW_W-1:0]   fixed_cw_o,
    output rd_status_e        status_o
);

    logic [PAR_W-1:0] syn;
    logic             odd;

    always_comb begin
        syn = '0;
        for (int p = 1; p < CW_W; p++) begin
            if (cw_i[p]) syn ^= PAR_W'(p);
        end
        odd        = ^cw_i;
        fixed_cw_o = cw_i;
        status_o   = ST_CLEAN;
        if (odd) begin
            if (int'(syn) < CW_W) begin
                fixed_cw_o[syn] = ~cw_i[syn];
                status_o        = ST_FIXED;
            end else begin
                status_o = ST_FATAL;
            end
        end else if (syn != '0) begin
            status_o = ST_FATAL;
        end
        data_o = secded_extract((status_o == ST_FIXED) ? fixed_cw_o : cw_i);
    end

endmodule

// File: rtl/ecc_rf_satcnt.sv
module ecc_rf_satcnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && count != CNT_MAX) begin
            count <= count + CNT_W'(1);
        end
    end

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_MAX && !clr) |=> count == CNT_MAX);

    // R8
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (count == $past(count) || count == $past(count) + CNT_W'(1)));

endmodule

// File: rtl/ecc_rf_bus.sv
module ecc_rf_bus
    import ecc_rf_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic [3:0]       be,
    input  logic [CNT_W-1:0] tally,
    output logic             ack,
    output logic [31:0]      rdata,
    output logic             clr
);

    bus_state_e state_q, state_d;
    logic       accept;

    assign accept = (state_q == BUS_IDLE) && valid;
    assign clr    = accept && (be != 4'b0000);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (valid) state_d = BUS_ACK;
            BUS_ACK:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= BUS_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (accept) begin
            rdata <= 32'(tally);
        end
    end

    assign ack = (state_q == BUS_ACK);

    // R11
    ack_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !ack) |=> ack);

    // R11
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

endmodule

// File: rtl/ecc_regfile.sv
module ecc_regfile
    import ecc_rf_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int CNT_W    = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        rd_status,
    input  logic              inj_en,
    input  logic [CW_W-1:0]   inj_mask,
    input  logic              bus_valid,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ack,
    output logic [31:0]       bus_rdata,
    output logic [31:0]       dbl_count
);

    op_kind_e          op;
    logic [CW_W-1:0]   entry_cw [NUM_REGS];
    logic [CW_W-1:0]   sel_cw;
    logic [CW_W-1:0]   enc_cw;
    logic [CW_W-1:0]   fix_cw;
    logic [DATA_W-1:0] dec_data;
    rd_status_e        dec_status;
    logic              sbe_inc, dbe_inc, sbe_clr;
    logic [CNT_W-1:0]  sbe_cnt, dbe_cnt;
    wire               unused_wdata = ^bus_wdata;

    always_comb begin
        if (wr_en)       op = OP_WRITE;
        else if (rd_en)  op = OP_READ;
        else if (inj_en) op = OP_INJECT;
        else             op = OP_IDLE;
    end

    assign enc_cw = secded_encode(wr_data);
    assign sel_cw = entry_cw[reg_sel];

    for (genvar e = 0; e < NUM_REGS; e++) begin : g_entry
        logic [CW_W-1:0] cw_q;
        logic            hit;
        assign hit = (reg_sel == IDX_W'(e));
        always_ff @(posedge clk) begin
            if (rst) begin
                cw_q <= '0;
            end else if (hit) begin
                unique case (op)
                    OP_WRITE:  cw_q <= enc_cw;
                    OP_READ:   if (dec_status == ST_FIXED) cw_q <= fix_cw;
                    OP_INJECT: cw_q <= cw_q ^ inj_mask;
                    OP_IDLE:   ;
                endcase
            end
        end
        assign entry_cw[e] = cw_q;
    end

    ecc_rf_decoder i_dec (
        .cw_i       (sel_cw),
        .data_o     (dec_data),
        .fixed_cw_o (fix_cw),
        .status_o   (dec_status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data   <= '0;
            rd_status <= ST_CLEAN;
        end else if (op == OP_READ) begin
            rd_data   <= dec_data;
            rd_status <= dec_status;
        end
    end

    assign sbe_inc = (op == OP_READ) && (dec_status == ST_FIXED);
    assign dbe_inc = (op == OP_READ) && (dec_status == ST_FATAL);

    ecc_rf_satcnt #(.CNT_W(CNT_W)) i_sbe_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (sbe_clr),
        .inc   (sbe_inc),
        .count (sbe_cnt)
    );

    ecc_rf_satcnt #(.CNT_W(CNT_W)) i_dbe_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (1'b0),
        .inc   (dbe_inc),
        .count (dbe_cnt)
    );

    assign dbl_count = 32'(dbe_cnt);

    ecc_rf_bus #(.CNT_W(CNT_W)) i_bus (
        .clk   (clk),
        .rst   (rst),
        .valid (bus_valid),
        .be    (bus_be),
        .tally (sbe_cnt),
        .ack   (bus_ack),
        .rdata (bus_rdata),
        .clr   (sbe_clr)
    );

    // R7
    status_legal_chk: assert property (@(posedge clk) disable iff (rst)
        rd_status != 2'b11);

    // R2
    hold_when_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_en || wr_en) |=> ($stable(rd_data) && $stable(rd_status)));

endmodule

// File: tb/test_ecc_regfile.sv
module test_ecc_regfile;

    localparam int CW   = 39;
    localparam int CNTW = 4;
    localparam int CMAX = (1 << CNTW) - 1;

    logic        clk = 1'b0;
    logic        rst, wr_en, rd_en, inj_en, bus_valid;
    logic [2:0]  reg_sel;
    logic [31:0] wr_data, bus_wdata;
    logic [CW-1:0] inj_mask;
    logic [3:0]  bus_be;
    logic [31:0] rd_data, bus_rdata, dbl_count;
    logic [1:0]  rd_status;
    logic        bus_ack;

    always #10 clk = ~clk;

    ecc_regfile #(.NUM_REGS(8), .CNT_W(CNTW)) i_ecc_regfile (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .rd_data(rd_data), .rd_status(rd_status),
        .inj_en(inj_en), .inj_mask(inj_mask), .bus_valid(bus_valid),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .dbl_count(dbl_count)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0]   m_data [8];
    logic [CW-1:0] m_flip [8];
    int            dpos [32];
    logic [31:0]   e_rd_data, e_brdata;
    logic [1:0]    e_status;
    logic          e_ack, m_bus_busy;
    int            m_sbe, m_dbe;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick(string req);
        bit accept;
        int nf;
        logic [31:0] raw;
        if (rst) begin
            for (int i = 0; i < 8; i++) begin m_data[i] = '0; m_flip[i] = '0; end
            e_rd_data = '0; e_status = 2'b00; e_ack = 0; e_brdata = '0;
            m_bus_busy = 0; m_sbe = 0; m_dbe = 0;
        end else begin
            accept = !m_bus_busy && bus_valid;
            if (accept) e_brdata = 32'(m_sbe);
            e_ack = accept;
            m_bus_busy = accept;
            if (wr_en) begin
                m_data[reg_sel] = wr_data;
                m_flip[reg_sel] = '0;
            end else if (rd_en) begin
                nf = $countones(m_flip[reg_sel]);
                if (nf == 0) begin
                    e_rd_data = m_data[reg_sel]; e_status = 2'b00;
                end else if (nf == 1) begin
                    e_rd_data = m_data[reg_sel]; e_status = 2'b01;
                    m_flip[reg_sel] = '0;
                    if (m_sbe < CMAX) m_sbe++;
                end else begin
                    raw = m_data[reg_sel];
                    for (int j = 0; j < 32; j++) if (m_flip[reg_sel][dpos[j]]) raw[j] = ~raw[j];
                    e_rd_data = raw; e_status = 2'b10;
                    if (m_dbe < CMAX) m_dbe++;
                end
            end else if (inj_en) begin
                m_flip[reg_sel] ^= inj_mask;
            end
            if (accept && bus_be != 4'b0000) m_sbe = 0;
        end
        @(posedge clk);
        @(negedge clk);
        chk(req, "rd_data", rd_data, e_rd_data);
        chk(req, "rd_status", 32'(rd_status), 32'(e_status));
        chk(req, "bus_ack", 32'(bus_ack), 32'(e_ack));
        chk(req, "bus_rdata", bus_rdata, e_brdata);
        chk(req, "dbl_count", dbl_count, 32'(m_dbe));
        wr_en = 0; rd_en = 0; inj_en = 0; bus_valid = 0; bus_be = '0;
    endtask

    task automatic do_write(int idx, logic [31:0] v, string req);
        reg_sel = 3'(idx); wr_data = v; wr_en = 1; tick(req);
    endtask
    task automatic do_read(int idx, string req);
        reg_sel = 3'(idx); rd_en = 1; tick(req);
    endtask
    task automatic do_inj(int idx, logic [CW-1:0] m, string req);
        reg_sel = 3'(idx); inj_mask = m; inj_en = 1; tick(req);
    endtask
    task automatic do_bus(logic [3:0] be, string req);
        bus_valid = 1; bus_be = be; bus_wdata = 32'hA5A5_0000 | 32'(be); tick(req);
    endtask

    function automatic logic [CW-1:0] bit_at(int p);
        return CW'(1) << p;
    endfunction

    initial begin
        int k = 0;
        for (int p = 1; p < CW; p++) if ((p & (p - 1)) != 0) begin dpos[k] = p; k++; end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; wr_en = 0; rd_en = 0; inj_en = 0; bus_valid = 0;
        reg_sel = '0; wr_data = '0; inj_mask = '0; bus_be = '0; bus_wdata = '0;
        @(negedge clk);
        tick("R1"); tick("R1");
        rst = 0;
        // R1: reset contents read back as zero, clean
        for (int i = 0; i < 8; i++) do_read(i, "R1");
        do_bus(4'b0000, "R1");
        tick("R1");

        // R2: plain write and read back of several patterns
        do_write(0, 32'hDEAD_BEEF, "R2");
        do_write(3, 32'h0000_0001, "R2");
        do_write(7, 32'hFFFF_FFFF, "R2");
        do_write(5, 32'h1234_5678, "R2");
        do_read(0, "R2"); do_read(3, "R2"); tick("R2"); tick("R2");
        do_read(7, "R2"); do_read(5, "R2");

        // R3 R4 R5: single flips in data, check and parity positions
        do_inj(3, bit_at(dpos[0]), "R3");
        do_read(3, "R4"); do_read(3, "R5");
        do_inj(7, bit_at(dpos[31]), "R3");
        do_read(7, "R4"); do_read(7, "R5");
        do_inj(5, bit_at(16), "R4");
        do_read(5, "R4"); do_read(5, "R5");
        do_inj(0, bit_at(0), "R4");
        do_read(0, "R4"); do_read(0, "R5");
        do_bus(4'b0000, "R8");
        tick("R8");

        // R6: double flips, raw data returned, not scrubbed
        do_inj(5, bit_at(dpos[4]) | bit_at(dpos[9]), "R6");
        do_read(5, "R6"); do_read(5, "R6");
        do_inj(0, bit_at(dpos[2]) | bit_at(8), "R3");
        do_read(0, "R6");
        do_write(5, 32'hCAFE_F00D, "R2");
        do_read(5, "R2");

        // R10: priority write > read > inject
        reg_sel = 3'd3; wr_data = 32'h5555_AAAA; wr_en = 1; rd_en = 1; tick("R10");
        reg_sel = 3'd3; rd_en = 1; inj_en = 1; inj_mask = bit_at(dpos[7]); tick("R10");
        reg_sel = 3'd3; wr_data = 32'h0F0F_0F0F; wr_en = 1; inj_en = 1; inj_mask = bit_at(1); tick("R10");
        do_read(3, "R10");

        // R11: held valid yields alternate accepts
        bus_valid = 1; bus_be = '0; tick("R11");
        bus_valid = 1; bus_be = '0; tick("R11");
        bus_valid = 1; bus_be = '0; tick("R11");
        tick("R11");

        // R12: clear with strobe, clear wins over concurrent increment
        do_bus(4'b0100, "R12");
        do_bus(4'b0000, "R12");
        do_inj(2, bit_at(dpos[13]), "R12");
        reg_sel = 3'd2; rd_en = 1; bus_valid = 1; bus_be = 4'b1000; tick("R12");
        tick("R12");
        do_bus(4'b0000, "R12");
        tick("R12");

        // R9: saturation of both tallies
        for (int n = 0; n < CMAX + 3; n++) begin
            do_inj(1, bit_at(dpos[n % 32]), "R9");
            do_read(1, "R9");
        end
        do_inj(6, bit_at(dpos[1]) | bit_at(dpos[3]), "R9");
        for (int n = 0; n < CMAX + 3; n++) do_read(6, "R9");
        do_bus(4'b0000, "R9");
        tick("R9");
        do_read(6, "R7");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule